// File: doc/BRIEF.md
# Interrupt Class Delivery Sequencer

This block decides, at an instruction boundary, which interrupt class a CPU core takes next, and keeps doing so until nothing more can be taken. It handles seven classes. Two are synchronous: a program exception and a supervisor call. Five are asynchronous: machine check, external, I/O, restart and stop. For each interrupt it picks, it raises one deliver request. An external delivery engine for that class answers with a done handshake. The sequencer then looks at the pending set again.

A supervisor call is chained straight into a program exception when a monitoring event is pending. When the chain ends, the sequencer reports three things: whether the hard-interrupt request may be dropped, whether the core must halt, and whether a halted core may resume. The halt decision depends on the wait bit of the status word and on whether a stop was delivered.

A sequence begins when the hard-interrupt request is seen. It cannot begin while the core sits between an execute-type instruction and its target instruction. Pending and enable inputs are sampled each time a class is chosen. A change made during a delivery takes effect on the next choice.

Top module: `irq_class_seq`

## Requirements
- R1: After reset the sequencer is idle: `busy`, `deliverValid`, `clearHardReq`, `haltReq`, `unhaltReq` and `coreHalted` are all 0.
- R2: No sequence starts while `execShadow` is 1, whatever the value of `startReq`. Once `execShadow` returns to 0 with `startReq` still held, the sequence starts.
- R3: A synchronous program exception (`syncPgm`) is chosen before a supervisor call (`syncSvc`). Either of them is chosen before any asynchronous class.
- R4: Asynchronous classes are chosen in this order: machine check (`asyncPend` bit 0), external (bit 1), I/O (bit 2), restart (bit 3), and stop (bit 4) last.
- R5: An asynchronous class can be chosen only when both its `asyncPend` bit and its `asyncEn` bit are 1. A pending class that is not enabled is never delivered.
- R6: `deliverClass` is one-hot, with these bit positions: 0 program, 1 supervisor call, 2 machine check, 3 external, 4 I/O, 5 restart, 6 stop. While `deliverValid` is 1 and `deliverDone` is 0, the request stays up and the class does not change.
- R7: After each delivery that is not a stop, the pending set is evaluated again. Deliveries continue until no class can be chosen.
- R8: A delivered stop ends the chain, even if a class that could be chosen became pending while the stop was being delivered.
- R9: After a supervisor call, if `perPending` is 1, the next delivery is the program class with `perChain` = 1 and `pgmIlen` equal to `svcIlen`. Every other delivery shows `perChain` = 0 and `pgmIlen` = 0.
- R10: At the end of a chain, `clearHardReq` pulses for one cycle if `anyPending` is 0, and does not pulse otherwise.
- R11: At the end of a chain, `haltReq` pulses and `coreHalted` becomes 1 if `waitBit` is 1 or a stop was delivered. Otherwise, if `coreHalted` was 1, `unhaltReq` pulses and `coreHalted` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Hard-interrupt request seen at an instruction boundary |
| execShadow | input | 1 | Core is between an execute-type instruction and its target |
| syncPgm | input | 1 | Synchronous program exception present |
| syncSvc | input | 1 | Supervisor call present |
| svcIlen | input | ILEN_W | Instruction length of the supervisor call |
| perPending | input | 1 | Monitoring event pending |
| asyncPend | input | NUM_ASYNC | Asynchronous pending bits, bit 0 = highest priority |
| asyncEn | input | NUM_ASYNC | Asynchronous enable bits, same order |
| anyPending | input | 1 | Any interrupt pending, deliverable or not |
| waitBit | input | 1 | Wait bit of the current status word |
| deliverDone | input | 1 | Delivery engine finished the current class |
| deliverValid | output | 1 | Deliver request |
| deliverClass | output | NUM_ASYNC+2 | One-hot class being delivered |
| perChain | output | 1 | Current program delivery is the chained monitoring exception |
| pgmIlen | output | ILEN_W | Instruction length for the chained program delivery |
| busy | output | 1 | A delivery chain is in progress |
| clearHardReq | output | 1 | Pulse: hard-interrupt request may be cleared |
| haltReq | output | 1 | Pulse: halt the core |
| unhaltReq | output | 1 | Pulse: resume a halted core |
| coreHalted | output | 1 | Halt state as last decided |

## Verification
Several pending sets are used. One has several asynchronous classes pending at once, to show the priority order. One mixes synchronous and asynchronous requests, to show that the synchronous ones go first. One has a class that is pending but not enabled, to show that the enable gates delivery and that the request line is then not cleared. A supervisor call with a monitoring event shows the chained program delivery and its length. Stop cases show that a stop ends the chain and halts the core, even when a new class arrives during the stop. The wait-bit, unhalt, empty-set and execute-shadow cases exercise each branch of the end-of-chain decision and the start gate.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SELECT, ST_DELIVER, ST_CHECK, ST_FINISH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrFlags;
    logic loadPick;
    logic loadPer;
    logic finish;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic pickAny;
    logic lastSvc;
    logic lastStop;
    logic perReq;
  } dpStatus_t;

  localparam int CLS_PGM = 0;
  localparam int CLS_SVC = 1;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         anyReq
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_chain
      assign grant[i]       = req[i] & ~blocked[i];
      assign blocked[i + 1] = blocked[i] | req[i];
    end
  endgenerate

  assign anyReq = blocked[N];
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        execShadow,
  input  logic        deliverDone,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        deliverValid,
  output logic        busy
);
  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq && !execShadow) begin
          strobe.clrFlags = 1'b1;
          stateNext       = ST_SELECT;
        end
      end
      ST_SELECT: begin
        if (status.pickAny) begin
          strobe.loadPick = 1'b1;
          stateNext       = ST_DELIVER;
        end else begin
          stateNext = ST_FINISH;
        end
      end
      ST_DELIVER: begin
        if (deliverDone) stateNext = ST_CHECK;
      end
      ST_CHECK: begin
        if (status.lastStop) begin
          stateNext = ST_FINISH;
        end else if (status.lastSvc && status.perReq) begin
          strobe.loadPer = 1'b1;
          stateNext      = ST_DELIVER;
        end else begin
          stateNext = ST_SELECT;
        end
      end
      ST_FINISH: begin
        strobe.finish = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign deliverValid = (state == ST_DELIVER);
  assign busy         = (state != ST_IDLE);

  // R2: a chain only begins on a cycle where the shadow was low
  p_start_gated_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(!execShadow));

  // R6: request is held until the engine answers
  p_request_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    (deliverValid && !deliverDone) |=> deliverValid);
endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter int NUM_ASYNC = 5,
  parameter int ILEN_W    = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic                   syncPgm,
  input  logic                   syncSvc,
  input  logic [ILEN_W-1:0]      svcIlen,
  input  logic                   perPending,
  input  logic [NUM_ASYNC-1:0]   asyncPend,
  input  logic [NUM_ASYNC-1:0]   asyncEn,
  input  logic                   anyPending,
  input  logic                   waitBit,
  output dpStatus_t              status,
  output logic [NUM_ASYNC+1:0]   classReg,
  output logic                   perChain,
  output logic [ILEN_W-1:0]      pgmIlen,
  output logic                   clearHardReq,
  output logic                   haltReq,
  output logic                   unhaltReq,
  output logic                   coreHalted
);
  localparam int NUM_CLS  = NUM_ASYNC + 2;
  localparam int CLS_STOP = NUM_CLS - 1;

  logic [NUM_CLS-1:0] reqVec, grantVec;
  logic               anyGrant;
  logic               lastSvc, lastStop, stopSeen;
  logic               haltNow;

  assign reqVec = {asyncPend & asyncEn, syncSvc, syncPgm};

  irq_prio_pick #(.N(NUM_CLS)) pick_i (
    .req    (reqVec),
    .grant  (grantVec),
    .anyReq (anyGrant)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      classReg <= '0;
      perChain <= 1'b0;
      pgmIlen  <= '0;
      lastSvc  <= 1'b0;
      lastStop <= 1'b0;
      stopSeen <= 1'b0;
    end else begin
      if (strobe.clrFlags) begin
        stopSeen <= 1'b0;
        lastSvc  <= 1'b0;
        lastStop <= 1'b0;
      end
      if (strobe.loadPick) begin
        classReg <= grantVec;
        perChain <= 1'b0;
        pgmIlen  <= '0;
        lastSvc  <= grantVec[CLS_SVC];
        lastStop <= grantVec[CLS_STOP];
        if (grantVec[CLS_STOP]) stopSeen <= 1'b1;
      end
      if (strobe.loadPer) begin
        classReg          <= '0;
        classReg[CLS_PGM] <= 1'b1;
        perChain          <= 1'b1;
        pgmIlen           <= svcIlen;
        lastSvc           <= 1'b0;
        lastStop          <= 1'b0;
      end
    end
  end

  assign haltNow = waitBit | stopSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clearHardReq <= 1'b0;
      haltReq      <= 1'b0;
      unhaltReq    <= 1'b0;
      coreHalted   <= 1'b0;
    end else begin
      clearHardReq <= strobe.finish & ~anyPending;
      haltReq      <= strobe.finish & haltNow;
      unhaltReq    <= strobe.finish & ~haltNow & coreHalted;
      if (strobe.finish) coreHalted <= haltNow;
    end
  end

  assign status.pickAny  = anyGrant;
  assign status.lastSvc  = lastSvc;
  assign status.lastStop = lastStop;
  assign status.perReq   = perPending;

  // R5: a loaded class was requested and enabled when it was picked
  p_grant_enabled_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPick |=> ((classReg & ~$past(reqVec)) == '0));

  // R9: the chained monitoring delivery is always the program class
  p_per_is_pgm_r9: assert property (@(posedge clk) disable iff (!rstN)
    perChain |-> (classReg[CLS_PGM] && $onehot(classReg)));

  // R11: halt and unhalt never together
  p_halt_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(haltReq && unhaltReq));

  // R11: unhalt only follows a halted core
  p_unhalt_from_halt_r11: assert property (@(posedge clk) disable iff (!rstN)
    unhaltReq |-> $past(coreHalted));
endmodule

// File: rtl/irq_class_seq.sv
module irq_class_seq
  import irq_seq_pkg::*;
#(
  parameter int NUM_ASYNC = 5,
  parameter int ILEN_W    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic                 execShadow,
  input  logic                 syncPgm,
  input  logic                 syncSvc,
  input  logic [ILEN_W-1:0]    svcIlen,
  input  logic                 perPending,
  input  logic [NUM_ASYNC-1:0] asyncPend,
  input  logic [NUM_ASYNC-1:0] asyncEn,
  input  logic                 anyPending,
  input  logic                 waitBit,
  input  logic                 deliverDone,
  output logic                 deliverValid,
  output logic [NUM_ASYNC+1:0] deliverClass,
  output logic                 perChain,
  output logic [ILEN_W-1:0]    pgmIlen,
  output logic                 busy,
  output logic                 clearHardReq,
  output logic                 haltReq,
  output logic                 unhaltReq,
  output logic                 coreHalted
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  irq_seq_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .execShadow   (execShadow),
    .deliverDone  (deliverDone),
    .status       (status),
    .strobe       (strobe),
    .deliverValid (deliverValid),
    .busy         (busy)
  );

  irq_seq_dp #(.NUM_ASYNC(NUM_ASYNC), .ILEN_W(ILEN_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .syncPgm      (syncPgm),
    .syncSvc      (syncSvc),
    .svcIlen      (svcIlen),
    .perPending   (perPending),
    .asyncPend    (asyncPend),
    .asyncEn      (asyncEn),
    .anyPending   (anyPending),
    .waitBit      (waitBit),
    .status       (status),
    .classReg     (deliverClass),
    .perChain     (perChain),
    .pgmIlen      (pgmIlen),
    .clearHardReq (clearHardReq),
    .haltReq      (haltReq),
    .unhaltReq    (unhaltReq),
    .coreHalted   (coreHalted)
  );

  // R6: a live request names exactly one class, stable until done
  p_class_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    deliverValid |-> $onehot(deliverClass));

  p_class_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (deliverValid && !deliverDone) |=> $stable(deliverClass));
endmodule

// File: tb/irq_class_seq_tb_top.sv
module irq_class_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 5;
  localparam int IW = 3;
  localparam int EV_CLR = 1000, EV_HALT = 1001, EV_UNHALT = 1002;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 0, execShadow = 0, syncPgm = 0, syncSvc = 0, perPending = 0;
  logic waitBit = 0, deliverDone = 0;
  logic [IW-1:0] svcIlen = '0;
  logic [NA-1:0] asyncPend = '0, asyncEn = '0;
  logic anyPending;
  logic deliverValid, perChain, busy, clearHardReq, haltReq, unhaltReq, coreHalted;
  logic [NA+1:0] deliverClass;
  logic [IW-1:0] pgmIlen;
  logic injectOnStop = 0;

  int checks = 0, errors = 0;
  int expQ[$];
  string tagQ[$];

  assign anyPending = (|asyncPend) | syncPgm | syncSvc | perPending;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_class_seq #(.NUM_ASYNC(NA), .ILEN_W(IW)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .execShadow(execShadow),
    .syncPgm(syncPgm), .syncSvc(syncSvc), .svcIlen(svcIlen),
    .perPending(perPending), .asyncPend(asyncPend), .asyncEn(asyncEn),
    .anyPending(anyPending), .waitBit(waitBit), .deliverDone(deliverDone),
    .deliverValid(deliverValid), .deliverClass(deliverClass),
    .perChain(perChain), .pgmIlen(pgmIlen), .busy(busy),
    .clearHardReq(clearHardReq), .haltReq(haltReq), .unhaltReq(unhaltReq),
    .coreHalted(coreHalted)
  );

  function automatic int delItem(int cls, int per, int ilen);
    return cls | (per << 8) | (ilen << 9);
  endfunction

  task automatic expect_ev(int item, string tag);
    expQ.push_back(item);
    tagQ.push_back(tag);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic observe(int item);
    if (expQ.size() == 0) begin
      check(1'b0, "unexpected event", item, -1);
    end else begin
      int e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(item == e, t, item, e);
    end
  endtask

  // monitor
  initial begin
    logic prevValid;
    prevValid = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (deliverValid && !prevValid) begin
          int cls;
          cls = -1;
          for (int k = 0; k < NA + 2; k++) if (deliverClass[k]) cls = k;
          observe(delItem(cls, int'(perChain), int'(pgmIlen)));
        end
        if (clearHardReq) observe(EV_CLR);
        if (haltReq)      observe(EV_HALT);
        if (unhaltReq)    observe(EV_UNHALT);
        prevValid = deliverValid;
      end
    end
  end

  // delivery engine model
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && deliverValid && !deliverDone) begin
        logic [NA+1:0] cls;
        logic pc;
        cls = deliverClass;
        pc  = perChain;
        if (cls[NA+1] && injectOnStop) begin
          asyncPend[0] = 1'b1;
          asyncEn[0]   = 1'b1;
        end
        @(negedge clk);
        deliverDone = 1'b1;
        @(negedge clk);
        deliverDone = 1'b0;
        if (cls[0] && pc)  perPending = 1'b0;
        else if (cls[0])   syncPgm = 1'b0;
        if (cls[1])        syncSvc = 1'b0;
        for (int k = 0; k < NA; k++) if (cls[k+2]) asyncPend[k] = 1'b0;
      end
    end
  end

  task automatic runSeq(string tag);
    @(negedge clk);
    startReq = 1'b1;
    while (!busy) @(negedge clk);
    startReq = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, tag, expQ.size(), 0);
    expQ.delete();
    tagQ.delete();
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({busy, deliverValid, clearHardReq, haltReq, unhaltReq, coreHalted} == 6'b0,
          "R1 reset outputs", int'({busy, deliverValid, coreHalted}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R1 idle after reset", int'(busy), 0);

    // R4/R7: three async classes in priority order, then clear
    asyncPend = 5'b00111; asyncEn = 5'b11111;
    expect_ev(delItem(2, 0, 0), "R4 mchk first");
    expect_ev(delItem(3, 0, 0), "R4 ext second");
    expect_ev(delItem(4, 0, 0), "R7 io chained");
    expect_ev(EV_CLR, "R10 clear when empty");
    runSeq("R7 chain complete");

    // R5: pending but disabled external is skipped, request kept
    asyncPend = 5'b00110; asyncEn = 5'b11101;
    expect_ev(delItem(4, 0, 0), "R5 only enabled io");
    runSeq("R10 no clear while pending");
    check(asyncPend[1] == 1'b1, "R5 ext left pending", int'(asyncPend[1]), 1);
    asyncPend = '0; asyncEn = 5'b11111;

    // R3: program, then supervisor call, then restart
    syncPgm = 1; syncSvc = 1; asyncPend = 5'b01000;
    expect_ev(delItem(0, 0, 0), "R3 program first");
    expect_ev(delItem(1, 0, 0), "R3 svc second");
    expect_ev(delItem(5, 0, 0), "R3 async after sync");
    expect_ev(EV_CLR, "R10 clear");
    runSeq("R3 sequence");

    // R9: svc followed by chained monitoring exception
    syncSvc = 1; perPending = 1; svcIlen = 3'd4;
    expect_ev(delItem(1, 0, 0), "R9 svc");
    expect_ev(delItem(0, 1, 4), "R9 chained program with svc length");
    expect_ev(EV_CLR, "R10 clear");
    runSeq("R9 sequence");

    // R11: stop delivered halts the core
    asyncPend = 5'b11000;
    expect_ev(delItem(5, 0, 0), "R4 restart before stop");
    expect_ev(delItem(6, 0, 0), "R4 stop last");
    expect_ev(EV_CLR, "R10 clear");
    expect_ev(EV_HALT, "R11 halt after stop");
    runSeq("R11 stop sequence");
    check(coreHalted == 1'b1, "R11 halted after stop", int'(coreHalted), 1);

    // R8: stop ends chain although mchk arrives during it
    injectOnStop = 1; asyncPend = 5'b10000;
    expect_ev(delItem(6, 0, 0), "R8 stop");
    expect_ev(EV_HALT, "R8 halt, no further delivery");
    runSeq("R8 chain ended by stop");
    injectOnStop = 0;
    check(asyncPend[0] == 1'b1, "R8 mchk not delivered", int'(asyncPend[0]), 1);
    asyncPend = '0;

    // R11: unhalt when no wait and no stop
    asyncPend = 5'b00100;
    expect_ev(delItem(4, 0, 0), "R11 io");
    expect_ev(EV_CLR, "R10 clear");
    expect_ev(EV_UNHALT, "R11 unhalt");
    runSeq("R11 unhalt sequence");
    check(coreHalted == 1'b0, "R11 resumed", int'(coreHalted), 0);

    // R11: wait bit halts
    waitBit = 1; asyncPend = 5'b00001;
    expect_ev(delItem(2, 0, 0), "R11 mchk");
    expect_ev(EV_CLR, "R10 clear");
    expect_ev(EV_HALT, "R11 halt on wait bit");
    runSeq("R11 wait sequence");
    check(coreHalted == 1'b1, "R11 halted on wait", int'(coreHalted), 1);
    waitBit = 0;

    // R2: execute shadow holds off the start
    begin
      bit sawBusy;
      sawBusy = 0;
      asyncPend = 5'b00010;
      execShadow = 1; startReq = 1;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        if (busy) sawBusy = 1;
      end
      check(!sawBusy, "R2 no start in shadow", int'(sawBusy), 0);
      expect_ev(delItem(3, 0, 0), "R2 ext after shadow");
      expect_ev(EV_CLR, "R10 clear");
      expect_ev(EV_UNHALT, "R11 unhalt");
      execShadow = 0;
      runSeq("R2 sequence after shadow");
    end

    // R10: nothing deliverable at all
    expect_ev(EV_CLR, "R10 empty chain clears");
    runSeq("R10 empty chain");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule